// File: doc/BRIEF.md
# Mixed-Width Shared Dual-Port Memory

This block holds 4096 bits of storage behind two ports that run on separate clocks. Each port has its own enable, write strobe, active-low synchronous output reset, address and data lines. Each port can use its own word width. Both ports address the same bits, so the block also converts data width: one side can store narrow words that the other side reads back as one wide word, or the reverse. In the default build, port A is 1024 words of 4 bits and port B is 256 words of 16 bits.

The array is built from two bit planes, and each plane is written by only one port. Each stored bit is the XOR of the two planes. With this structure, each port's write logic stays inside its own clock domain. An initialisation parameter sets the contents at power-up. Each port's output register has its own reset value.

Top module: `dual_view_ram`

## Requirements
- R1: A narrow word written on port A at address n occupies array bits [n*A_WIDTH +: A_WIDTH]. With the default widths, port B word m holds port A words 4m..4m+3, and the lowest A address sits in bits [3:0].
- R2: A wide word written on port B at address m occupies array bits [m*B_WIDTH +: B_WIDTH]. Port A then reads each slice of it at the matching narrow address.
- R3: Reads are synchronous. The output register changes only on that port's rising clock edge and shows the word at the address presented before that edge.
- R4: While a port's enable is low, its write strobe and reset are ignored. The port's output register holds its value and the array is not modified by that port.
- R5: With enable high, reset inactive and the write strobe high, the word is stored and the output register loads the incoming data on the same edge (write-first).
- R6: With enable high and the reset input low, the output register loads that port's reset-value parameter. If the write strobe is also high, the write still takes place.
- R7: At power-up, array bit i equals bit i of the INIT parameter, and each output register holds its reset-value parameter.
- R8: When one port reads bits that the other port writes on the same edge (both ports on one clock), the read returns the contents from before that write.
- R9: Each port's data width is a parameter chosen from 1, 2, 4, 8 and 16. Its address width is log2(4096 / width): 10 bits for port A and 8 bits for port B by default.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Port A clock |
| en_a | input | 1 | Port A enable; gates all port A activity |
| we_a | input | 1 | Port A write strobe |
| rst_a_n | input | 1 | Port A output reset, active low, synchronous |
| addr_a | input | A_AW (10) | Port A word address |
| din_a | input | A_WIDTH (4) | Port A write data |
| dout_a | output | A_WIDTH (4) | Port A registered read data |
| clk_b | input | 1 | Port B clock |
| en_b | input | 1 | Port B enable; gates all port B activity |
| we_b | input | 1 | Port B write strobe |
| rst_b_n | input | 1 | Port B output reset, active low, synchronous |
| addr_b | input | B_AW (8) | Port B word address |
| din_b | input | B_WIDTH (16) | Port B write data |
| dout_b | output | B_WIDTH (16) | Port B registered read data |

## Verification
On every edge, the bound checker confirms the local rules of each port's output register: it holds while enable is low, it takes the reset value when reset is low, and it returns the written data on a write. Several behaviours depend on the array contents, so only the bench scenarios can show them. These are the bit mapping between the narrow and wide views in both directions, the power-up contents, writes that are suppressed while a port is disabled, and a same-edge read of bits the other port is overwriting returning old data. The bench therefore keeps a bit-level shadow of the array and compares both outputs against it after every directed and random step.

// File: rtl/dvr_pkg.sv
// dvr_pkg: shared constants and helpers for the mixed-width dual-port memory.
// Assumes the array size is a power of two and each port width divides it.
package dvr_pkg;
    localparam int TOTAL_BITS = 4096;

    // Legal data widths for a port.
    function automatic bit width_ok(input int w);
        return (w == 1) || (w == 2) || (w == 4) || (w == 8) || (w == 16);
    endfunction

    // Address width for a port of the given data width.
    function automatic int addr_bits(input int w);
        return $clog2(TOTAL_BITS / w);
    endfunction
endpackage

// File: rtl/dvr_bank.sv
// dvr_bank: one bit plane of the shared array, written by a single port.
// A write stores din XOR the other plane, so the XOR of both planes holds din.
// Assumes the other plane is stable around this port's clock edge.
module dvr_bank
    import dvr_pkg::*;
#(
    parameter int WIDTH = 4,
    parameter logic [TOTAL_BITS-1:0] PLANE_INIT = '0,
    localparam int AW = addr_bits(WIDTH)
) (
    input  logic                  clk,
    input  logic                  wr,
    input  logic [AW-1:0]         addr,
    input  logic [WIDTH-1:0]      din,
    input  logic [TOTAL_BITS-1:0] other_bits,
    output logic [TOTAL_BITS-1:0] own_bits
);
    logic [TOTAL_BITS-1:0] plane_q = PLANE_INIT;
    int                    base;

    // Bit offset of the addressed word.
    always_comb base = int'(addr) * WIDTH;

    // Store the word so that the XOR of the two planes equals din.
    always_ff @(posedge clk) begin
        if (wr) begin
            plane_q[base +: WIDTH] <= din ^ other_bits[base +: WIDTH];
        end
    end

    assign own_bits = plane_q;
endmodule

// File: rtl/dvr_outreg.sv
// dvr_outreg: output register of one port.
// Priority: enable gates everything; reset value beats write data; write data beats read data.
module dvr_outreg #(
    parameter int WIDTH = 4,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             en,
    input  logic             rst_n,
    input  logic             we,
    input  logic [WIDTH-1:0] wr_word,
    input  logic [WIDTH-1:0] rd_word,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] q = RST_VAL;

    // Choose the next output word while enabled; otherwise hold.
    always_ff @(posedge clk) begin
        if (en) begin
            if (!rst_n)  q <= RST_VAL;
            else if (we) q <= wr_word;
            else         q <= rd_word;
        end
    end

    assign dout = q;
endmodule

// File: rtl/dvr_port.sv
// dvr_port: one complete port, made of its own bit plane, the read decode across
// both planes and its output register. Assumes WIDTH is one of the legal widths.
module dvr_port
    import dvr_pkg::*;
#(
    parameter int WIDTH = 4,
    parameter logic [TOTAL_BITS-1:0] PLANE_INIT = '0,
    parameter logic [WIDTH-1:0] RST_VAL = '0,
    localparam int AW = addr_bits(WIDTH)
) (
    input  logic                  clk,
    input  logic                  en,
    input  logic                  we,
    input  logic                  rst_n,
    input  logic [AW-1:0]         addr,
    input  logic [WIDTH-1:0]      din,
    input  logic [TOTAL_BITS-1:0] other_bits,
    output logic [TOTAL_BITS-1:0] own_bits,
    output logic [WIDTH-1:0]      dout
);
    logic [WIDTH-1:0] rd_word;
    int               rd_base;

    // Stop elaboration on an unsupported width.
    if (!width_ok(WIDTH)) begin : g_bad_width
        $error("dvr_port: unsupported WIDTH %0d", WIDTH);
    end

    dvr_bank #(
        .WIDTH      (WIDTH),
        .PLANE_INIT (PLANE_INIT)
    ) u_bank (
        .clk        (clk),
        .wr         (en & we),
        .addr       (addr),
        .din        (din),
        .other_bits (other_bits),
        .own_bits   (own_bits)
    );

    // Rebuild the addressed word from both planes.
    always_comb begin
        rd_base = int'(addr) * WIDTH;
        rd_word = own_bits[rd_base +: WIDTH] ^ other_bits[rd_base +: WIDTH];
    end

    dvr_outreg #(
        .WIDTH   (WIDTH),
        .RST_VAL (RST_VAL)
    ) u_out (
        .clk     (clk),
        .en      (en),
        .rst_n   (rst_n),
        .we      (we),
        .wr_word (din),
        .rd_word (rd_word),
        .dout    (dout)
    );
endmodule

// File: rtl/dual_view_ram.sv
// dual_view_ram: 4096-bit memory with two independent synchronous ports that
// may use different widths over the same bits. Port A's plane carries INIT and
// port B's plane starts at zero, so the array starts equal to INIT.
// Assumes no same-edge writes from both ports to overlapping bits.
module dual_view_ram
    import dvr_pkg::*;
#(
    parameter int A_WIDTH = 4,
    parameter int B_WIDTH = 16,
    parameter logic [TOTAL_BITS-1:0] INIT = '0,
    parameter logic [A_WIDTH-1:0] A_RST = '0,
    parameter logic [B_WIDTH-1:0] B_RST = '0,
    localparam int A_AW = addr_bits(A_WIDTH),
    localparam int B_AW = addr_bits(B_WIDTH)
) (
    input  logic               clk_a,
    input  logic               en_a,
    input  logic               we_a,
    input  logic               rst_a_n,
    input  logic [A_AW-1:0]    addr_a,
    input  logic [A_WIDTH-1:0] din_a,
    output logic [A_WIDTH-1:0] dout_a,
    input  logic               clk_b,
    input  logic               en_b,
    input  logic               we_b,
    input  logic               rst_b_n,
    input  logic [B_AW-1:0]    addr_b,
    input  logic [B_WIDTH-1:0] din_b,
    output logic [B_WIDTH-1:0] dout_b
);
    logic [TOTAL_BITS-1:0] plane_a;
    logic [TOTAL_BITS-1:0] plane_b;

    dvr_port #(
        .WIDTH      (A_WIDTH),
        .PLANE_INIT (INIT),
        .RST_VAL    (A_RST)
    ) u_port_a (
        .clk        (clk_a),
        .en         (en_a),
        .we         (we_a),
        .rst_n      (rst_a_n),
        .addr       (addr_a),
        .din        (din_a),
        .other_bits (plane_b),
        .own_bits   (plane_a),
        .dout       (dout_a)
    );

    dvr_port #(
        .WIDTH      (B_WIDTH),
        .PLANE_INIT ('0),
        .RST_VAL    (B_RST)
    ) u_port_b (
        .clk        (clk_b),
        .en         (en_b),
        .we         (we_b),
        .rst_n      (rst_b_n),
        .addr       (addr_b),
        .din        (din_b),
        .other_bits (plane_a),
        .own_bits   (plane_b),
        .dout       (dout_b)
    );
endmodule

// File: rtl/dual_view_ram_chk.sv
// dual_view_ram_chk: per-edge rules of both output registers, bound to dual_view_ram.
// Each port's properties are enabled from that port's second clock edge on.
module dual_view_ram_chk #(
    parameter int A_WIDTH = 4,
    parameter int B_WIDTH = 16,
    parameter logic [A_WIDTH-1:0] A_RST = '0,
    parameter logic [B_WIDTH-1:0] B_RST = '0
) (
    input logic               clk_a,
    input logic               en_a,
    input logic               we_a,
    input logic               rst_a_n,
    input logic [A_WIDTH-1:0] din_a,
    input logic [A_WIDTH-1:0] dout_a,
    input logic               clk_b,
    input logic               en_b,
    input logic               we_b,
    input logic               rst_b_n,
    input logic [B_WIDTH-1:0] din_b,
    input logic [B_WIDTH-1:0] dout_b
);
    logic live_a = 1'b0;
    logic live_b = 1'b0;

    // Mark that port A has seen an edge.
    always_ff @(posedge clk_a) live_a <= 1'b1;
    // Mark that port B has seen an edge.
    always_ff @(posedge clk_b) live_b <= 1'b1;

    // R4
    a_hold_chk: assert property (@(posedge clk_a) disable iff (!live_a)
        !en_a |=> $stable(dout_a));
    // R4
    b_hold_chk: assert property (@(posedge clk_b) disable iff (!live_b)
        !en_b |=> $stable(dout_b));
    // R6
    a_rst_val_chk: assert property (@(posedge clk_a) disable iff (!live_a)
        en_a && !rst_a_n |=> dout_a == A_RST);
    // R6
    b_rst_val_chk: assert property (@(posedge clk_b) disable iff (!live_b)
        en_b && !rst_b_n |=> dout_b == B_RST);
    // R5
    a_wr_first_chk: assert property (@(posedge clk_a) disable iff (!live_a)
        en_a && rst_a_n && we_a |=> dout_a == $past(din_a));
    // R5
    b_wr_first_chk: assert property (@(posedge clk_b) disable iff (!live_b)
        en_b && rst_b_n && we_b |=> dout_b == $past(din_b));
endmodule

bind dual_view_ram dual_view_ram_chk #(
    .A_WIDTH (A_WIDTH),
    .B_WIDTH (B_WIDTH),
    .A_RST   (A_RST),
    .B_RST   (B_RST)
) u_chk (
    .clk_a   (clk_a),
    .en_a    (en_a),
    .we_a    (we_a),
    .rst_a_n (rst_a_n),
    .din_a   (din_a),
    .dout_a  (dout_a),
    .clk_b   (clk_b),
    .en_b    (en_b),
    .we_b    (we_b),
    .rst_b_n (rst_b_n),
    .din_b   (din_b),
    .dout_b  (dout_b)
);

// File: tb/dual_view_ram_tb.sv
// Bench for dual_view_ram: directed corner cases followed by seeded random steps,
// compared against a bit-level shadow of the array.
module dual_view_ram_tb;
    localparam int WA = 4;
    localparam int WB = 16;
    localparam logic [WA-1:0] RST_A = 4'h9;
    localparam logic [WB-1:0] RST_B = 16'h5AA5;

    function automatic logic [4095:0] make_pattern();
        logic [4095:0] p;
        for (int i = 0; i < 128; i++) p[i*32 +: 32] = (i * 32'h9E3779B1) ^ 32'h5A5A0F0F;
        return p;
    endfunction
    localparam logic [4095:0] PAT = make_pattern();

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic en_a = 0, we_a = 0, rst_a_n = 1;
    logic [9:0] addr_a = '0;
    logic [WA-1:0] din_a = '0, dout_a;
    logic en_b = 0, we_b = 0, rst_b_n = 1;
    logic [7:0] addr_b = '0;
    logic [WB-1:0] din_b = '0, dout_b;

    dual_view_ram #(
        .A_WIDTH (WA), .B_WIDTH (WB), .INIT (PAT), .A_RST (RST_A), .B_RST (RST_B)
    ) u_dut (
        .clk_a (clk), .en_a (en_a), .we_a (we_a), .rst_a_n (rst_a_n),
        .addr_a (addr_a), .din_a (din_a), .dout_a (dout_a),
        .clk_b (clk), .en_b (en_b), .we_b (we_b), .rst_b_n (rst_b_n),
        .addr_b (addr_b), .din_b (din_b), .dout_b (dout_b)
    );

    int checks = 0, errors = 0;
    logic done = 0;
    logic [4095:0] model = PAT;
    logic [WA-1:0] exp_a = RST_A;
    logic [WB-1:0] exp_b = RST_B;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // One edge of stimulus on both ports, then compare both outputs.
    task automatic step(input logic ea, wa, ra_n, input logic [9:0] aa, input logic [WA-1:0] da,
                        input logic eb, wb, rb_n, input logic [7:0] ab, input logic [WB-1:0] db,
                        input string ta, input string tb);
        @(negedge clk);
        en_a = ea; we_a = wa; rst_a_n = ra_n; addr_a = aa; din_a = da;
        en_b = eb; we_b = wb; rst_b_n = rb_n; addr_b = ab; din_b = db;
        #1;
        chk("R3 A before edge", 32'(dout_a), 32'(exp_a));
        chk("R3 B before edge", 32'(dout_b), 32'(exp_b));
        if (ea) exp_a = !ra_n ? RST_A : (wa ? da : model[int'(aa)*WA +: WA]);
        if (eb) exp_b = !rb_n ? RST_B : (wb ? db : model[int'(ab)*WB +: WB]);
        if (ea && wa) model[int'(aa)*WA +: WA] = da;
        if (eb && wb) model[int'(ab)*WB +: WB] = db;
        @(posedge clk);
        #1;
        chk(ta, 32'(dout_a), 32'(exp_a));
        chk(tb, 32'(dout_b), 32'(exp_b));
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        #1;
        // R7 power-up output registers
        chk("R7 A power-up out", 32'(dout_a), 32'(RST_A));
        chk("R7 B power-up out", 32'(dout_b), 32'(RST_B));
        // R9 address widths
        chk("R9 addr_a width", 32'($bits(addr_a)), 32'd10);
        chk("R9 addr_b width", 32'($bits(addr_b)), 32'd8);
        // R6 reset of both outputs
        step(1,0,0,10'd0,4'h0, 1,0,0,8'd0,16'h0, "R6 A reset", "R6 B reset");
        // R7 power-up contents
        step(1,0,1,10'd5,4'h0, 1,0,1,8'd3,16'h0, "R7 A init read", "R7 B init read");
        chk("R7 A init value", 32'(dout_a), 32'(PAT[20 +: 4]));
        chk("R7 B init value", 32'(dout_b), 32'(PAT[48 +: 16]));
        // R1 narrow writes gathered by the wide port
        for (int k = 0; k < 4; k++)
            step(1,1,1,10'(8+k),4'(k+1), 0,0,1,8'd0,16'h0, "R5 A write-first", "R4 B idle");
        step(0,0,1,10'd0,4'h0, 1,0,1,8'd2,16'h0, "R4 A idle", "R1 B gathers");
        chk("R1 B word 2", 32'(dout_b), 32'h4321);
        // R2 wide write split across narrow reads
        step(0,0,1,10'd0,4'h0, 1,1,1,8'd10,16'hBEEF, "R4 A idle", "R5 B write-first");
        for (int k = 0; k < 4; k++)
            step(1,0,1,10'(40+k),4'h0, 0,0,1,8'd0,16'h0, "R2 A slice", "R4 B idle");
        chk("R2 A top slice", 32'(dout_a), 32'hB);
        // R4 disabled port ignores write and reset
        step(0,1,0,10'd40,4'h3, 0,1,0,8'd10,16'h1111, "R4 A held", "R4 B held");
        step(1,0,1,10'd40,4'h0, 1,0,1,8'd10,16'h0, "R4 A unchanged", "R4 B unchanged");
        chk("R4 A content", 32'(dout_a), 32'hF);
        chk("R4 B content", 32'(dout_b), 32'hBEEF);
        // R6 reset with write
        step(0,0,1,10'd0,4'h0, 1,1,0,8'd20,16'h1234, "R4 A idle", "R6 B reset on write");
        step(0,0,1,10'd0,4'h0, 1,0,1,8'd20,16'h0, "R4 A idle", "R6 B write kept");
        chk("R6 B written", 32'(dout_b), 32'h1234);
        // R8 same-edge read of bits being overwritten
        step(1,1,1,10'd80,4'h7, 1,0,1,8'd20,16'h0, "R5 A write", "R8 B old data");
        chk("R8 B old", 32'(dout_b), 32'h1234);
        step(0,0,1,10'd0,4'h0, 1,0,1,8'd20,16'h0, "R4 A idle", "R8 B new data");
        chk("R8 B new", 32'(dout_b), 32'h1237);
        // Random mix, R1 R2 R4 R5 R6 R8
        seed = $urandom(32'd2718);
        for (int n = 0; n < 600; n++) begin
            logic ea, wa, ra, eb, wb, rb;
            logic [9:0] aa; logic [7:0] ab;
            int alo, blo;
            ea = ($urandom % 4) != 0; wa = ($urandom % 3) == 0; ra = ($urandom % 10) != 0;
            eb = ($urandom % 4) != 0; wb = ($urandom % 3) == 0; rb = ($urandom % 10) != 0;
            aa = 10'($urandom % 64); ab = 8'($urandom % 16);
            alo = int'(aa) * WA; blo = int'(ab) * WB;
            if (ea && wa && eb && wb && alo < blo + WB && blo < alo + WA) wb = 0;
            step(ea,wa,ra,aa,4'($urandom), eb,wb,rb,ab,16'($urandom),
                 "R1 R5 R6 R8 random A", "R2 R5 R6 R8 random B");
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule